// File: doc/BRIEF.md
# Ping-Pong Peripheral DMA Channel

This block is one peripheral DMA channel that has two buffer slots, A and B. Each slot holds a start address and a byte count. Software loads a slot, marks it started and sets the run bit. The engine then moves data between a byte-addressed memory port and one peripheral data stream. When the active slot finishes, the engine moves on to the other slot if that slot was also started, so software can refill one slot while the other is being consumed. The active slot is shown by a buffer-in-use flag.

Software sees a 32-byte register window. The control and status byte has three aliases: one where each written 1 sets a bit, one where each written 1 clears a bit, and one that reads the byte back. A device-configuration byte selects the following:
- the transfer direction;
- the byte order of 16-bit items;
- the burst length;
- the item width;
- which of 16 peripheral request lines paces the bursts.

An interrupt output reports finished buffers and errors.

All three data paths use valid/ready handshakes:
- the memory request (`mem_valid`/`mem_ready`);
- the outgoing peripheral stream (`tx_valid`/`tx_ready`);
- the incoming peripheral stream (`rx_valid`/`rx_ready`).

A transfer takes place on a cycle where both valid and ready are high. A valid that is raised stays high, with its payload unchanged, until ready is seen. Any sender or receiver may stall for any number of cycles. For a memory read, the data on `mem_rdata` belongs to the cycle in which the request is accepted. `mem_rdata[7:0]` is the byte at `mem_addr`, and `mem_rdata[15:8]` is the byte at the next address.

Top module: `dbuf_dma_chan`

## Requirements
- R1: After reset the status byte and the device-configuration byte read 0, the buffer-in-use flag selects A, and `irq` is low.
- R2: Register offsets:
  - 0x00: device configuration.
  - 0x04: status set alias. Each 1 written sets that status bit.
  - 0x08: status clear alias. Each 1 written clears that status bit.
  - 0x0C: status read.
  - 0x10 and 0x14: start address and count of A.
  - 0x18 and 0x1C: start address and count of B.
  - Zeros written to either alias change nothing. Bit 7 of the status byte ignores all writes. The set and clear aliases read as 0.
- R3: Status bit positions:
  - bit 0: run
  - bit 1: interrupt enable
  - bit 2: error
  - bit 3: A done
  - bit 4: A started
  - bit 5: B done
  - bit 6: B started
  - bit 7: buffer in use (1 means B).
- R4: Device-configuration bit positions:
  - bit 0: direction (1 = peripheral to memory).
  - bit 1: byte order (1 = big).
  - bit 2: burst length (0 = 4 items, 1 = 8 items).
  - bit 3: item width (0 = 8-bit, 1 = 16-bit).
  - bits 7:4: request line number.
  - The byte reads back as written.
- R5: A buffer with count N moves ceil(N/w) items, where w is 1 or 2 bytes. After each item the active start address grows by w and the count falls by w, never below 0. Reading the registers therefore shows the current position.
- R6: An 8-bit item uses byte lane 0, and the unused high lane reads as 0 on the peripheral stream. A 16-bit item uses both lanes (memory byte enable 2'b11 against 2'b01 for 8-bit) and has its two bytes swapped when big byte order is selected. This applies in both directions.
- R7: When the last item of the active buffer moves, its done bit sets and its started bit clears. If the other slot's started bit is set, buffer in use toggles. Otherwise it keeps its value.
- R8: `irq` is high exactly when interrupt enable is set and at least one of error, A done or B done is set. A clear-alias write that clears these bits drops `irq` on the next cycle.
- R9: A started, active buffer whose count is 0 finishes without any memory or peripheral transfer.
- R10: An active started buffer whose start address is not a multiple of 4 sets error and clears run, and moves no data. This check is made before the zero-count check.
- R11: Clearing run during a transfer stops the channel at the end of the current burst, with address and count kept. Setting run again continues from that point.
- R12: A burst begins only while the selected request line is high. A burst holds `dack` high and covers 4 or 8 items, or fewer if the buffer ends first.
- R13: Every valid/ready interface holds its valid signal and payload steady while stalled, and data is correct under random stalls on all three interfaces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset (word aligned) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the item |
| mem_be | output | 2 | Byte-lane enables |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the accept cycle |
| dreq | input | 16 | Peripheral request lines |
| dack | output | 1 | High while a burst is in progress |
| tx_valid | output | 1 | Outgoing item valid |
| tx_ready | input | 1 | Peripheral accepts the outgoing item |
| tx_data | output | 16 | Outgoing item |
| rx_valid | input | 1 | Incoming item valid |
| rx_ready | output | 1 | Channel accepts the incoming item |
| rx_data | input | 16 | Incoming item |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a run bit cleared in the middle of a burst. Observing it means catching the channel between bursts with a partly consumed buffer and then resuming without losing or repeating an item. The stimulus clears run a few cycles into a long 8-item-burst buffer, with no stalls so the timing is known. It then checks that the bus stays silent and that the consumed byte count is a multiple of the burst size. Finally it sets run again and compares a checksum taken over the whole item sequence. A second case is the hand-over between the two slots: both slots are preloaded and the final buffer-in-use value and the combined checksum are checked.

// File: rtl/dbuf_dma_pkg.sv
package dbuf_dma_pkg;
  // register word index (byte offset >> 2)
  localparam logic [2:0] IX_DEV  = 3'd0;
  localparam logic [2:0] IX_SET  = 3'd1;
  localparam logic [2:0] IX_CLR  = 3'd2;
  localparam logic [2:0] IX_STAT = 3'd3;
  localparam logic [2:0] IX_SA   = 3'd4;
  localparam logic [2:0] IX_CA   = 3'd5;
  localparam logic [2:0] IX_SB   = 3'd6;
  localparam logic [2:0] IX_CB   = 3'd7;

  // status bit positions
  localparam int SB_RUN   = 0;
  localparam int SB_IE    = 1;
  localparam int SB_ERR   = 2;
  localparam int SB_DONEA = 3;
  localparam int SB_STRTA = 4;
  localparam int SB_DONEB = 5;
  localparam int SB_STRTB = 6;
  localparam int SB_BIU   = 7;

  typedef struct packed {
    logic [3:0] sel;
    logic       wide;
    logic       burst8;
    logic       big;
    logic       p2m;
  } dev_cfg_t;

  typedef enum logic [2:0] {E_IDLE, E_MRD, E_PTX, E_PRX, E_MWR} eng_st_t;

  function automatic int done_pos(logic slot);
    return slot ? SB_DONEB : SB_DONEA;
  endfunction

  function automatic int strt_pos(logic slot);
    return slot ? SB_STRTB : SB_STRTA;
  endfunction
endpackage

// File: rtl/dbuf_dma_lane.sv
module dbuf_dma_lane #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] din,
  input  logic          wide,
  input  logic          big,
  output logic [DW-1:0] dout
);
  localparam int HW = DW / 2;

  always_comb begin
    if (!wide)
      dout = {{HW{1'b0}}, din[HW-1:0]};
    else if (big)
      dout = {din[HW-1:0], din[DW-1:HW]};
    else
      dout = din;
  end
endmodule

// File: rtl/dbuf_dma_regs.sv
module dbuf_dma_regs
  import dbuf_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 13,
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    wr_idx,
  input  logic [RW-1:0] wr_data,
  input  logic [2:0]    rd_idx,
  output logic [RW-1:0] rd_data,
  input  logic          eng_adv,
  input  logic          eng_fin,
  input  logic          eng_err,
  input  logic [CW-1:0] eng_step,
  output logic [7:0]    status,
  output logic [7:0]    dev,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt
);
  logic [7:0]    stat_q, stat_n;
  logic [7:0]    dev_q;
  logic [AW-1:0] sa_all [2];
  logic [CW-1:0] cnt_all [2];
  logic          biu;

  assign biu = stat_q[SB_BIU];

  always_comb begin
    stat_n = stat_q;
    if (eng_fin) begin
      stat_n[done_pos(biu)] = 1'b1;
      stat_n[strt_pos(biu)] = 1'b0;
      if (stat_q[strt_pos(!biu)])
        stat_n[SB_BIU] = !biu;
    end
    if (eng_err) begin
      stat_n[SB_ERR] = 1'b1;
      stat_n[SB_RUN] = 1'b0;
    end
    if (wr_en && wr_idx == IX_SET)
      stat_n[6:0] = stat_n[6:0] | wr_data[6:0];
    if (wr_en && wr_idx == IX_CLR)
      stat_n[6:0] = stat_n[6:0] & ~wr_data[6:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      dev_q  <= '0;
    end else begin
      stat_q <= stat_n;
      if (wr_en && wr_idx == IX_DEV)
        dev_q <= wr_data[7:0];
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_slot
    logic [AW-1:0] sa_q;
    logic [CW-1:0] cnt_q;
    logic          mine, wr_sa, wr_cnt;

    assign mine   = eng_adv && (biu == s[0]);
    assign wr_sa  = wr_en && wr_idx == (s == 0 ? IX_SA : IX_SB);
    assign wr_cnt = wr_en && wr_idx == (s == 0 ? IX_CA : IX_CB);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sa_q  <= '0;
        cnt_q <= '0;
      end else begin
        if (wr_sa)
          sa_q <= wr_data[AW-1:0];
        else if (mine)
          sa_q <= sa_q + AW'(eng_step);
        if (wr_cnt)
          cnt_q <= wr_data[CW-1:0];
        else if (mine)
          cnt_q <= (cnt_q <= eng_step) ? '0 : cnt_q - eng_step;
      end
    end

    assign sa_all[s]  = sa_q;
    assign cnt_all[s] = cnt_q;
  end

  always_comb begin
    case (rd_idx)
      IX_DEV:  rd_data = RW'(dev_q);
      IX_STAT: rd_data = RW'(stat_q);
      IX_SA:   rd_data = RW'(sa_all[0]);
      IX_CA:   rd_data = RW'(cnt_all[0]);
      IX_SB:   rd_data = RW'(sa_all[1]);
      IX_CB:   rd_data = RW'(cnt_all[1]);
      default: rd_data = '0;
    endcase
  end

  assign status   = stat_q;
  assign dev      = dev_q;
  assign cur_addr = sa_all[biu];
  assign cur_cnt  = cnt_all[biu];
endmodule

// File: rtl/dbuf_dma_engine.sv
module dbuf_dma_engine
  import dbuf_dma_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 13,
  parameter int DW   = 16,
  parameter int NREQ = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            strt_cur,
  input  logic [7:0]      dev,
  input  logic [AW-1:0]   cur_addr,
  input  logic [CW-1:0]   cur_cnt,
  input  logic [NREQ-1:0] dreq,
  output logic            adv,
  output logic            fin,
  output logic            err,
  output logic [CW-1:0]   step,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW/8-1:0] mem_be,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            dack,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [DW-1:0]   tx_data,
  input  logic            rx_valid,
  output logic            rx_ready,
  input  logic [DW-1:0]   rx_data
);
  localparam int BEW = DW / 8;

  dev_cfg_t      cfg;
  eng_st_t       st_q, st_n;
  logic [2:0]    bcnt_q, bcnt_n;
  logic [DW-1:0] hold_q, hold_n;
  logic [DW-1:0] mem_lane, rx_lane;
  logic          burst_end, last_item, beat_done;
  eng_st_t       fetch_st;

  assign cfg = dev_cfg_t'(dev);

  dbuf_dma_lane #(.DW(DW)) u_mlane (
    .din(mem_rdata), .wide(cfg.wide), .big(cfg.big), .dout(mem_lane));
  dbuf_dma_lane #(.DW(DW)) u_rlane (
    .din(rx_data), .wide(cfg.wide), .big(cfg.big), .dout(rx_lane));

  assign step      = {{(CW-2){1'b0}}, cfg.wide, ~cfg.wide};
  assign last_item = cur_cnt <= step;
  assign burst_end = cfg.burst8 ? (bcnt_q == 3'd7) : (bcnt_q == 3'd3);
  assign fetch_st  = cfg.p2m ? E_PRX : E_MRD;
  assign beat_done = (st_q == E_PTX && tx_ready) || (st_q == E_MWR && mem_ready);

  always_comb begin
    st_n   = st_q;
    bcnt_n = bcnt_q;
    hold_n = hold_q;
    adv    = 1'b0;
    fin    = 1'b0;
    err    = 1'b0;
    case (st_q)
      E_IDLE: begin
        if (run && strt_cur) begin
          if (cur_addr[1:0] != 2'b00)
            err = 1'b1;
          else if (cur_cnt == '0)
            fin = 1'b1;
          else if (dreq[cfg.sel]) begin
            st_n   = fetch_st;
            bcnt_n = '0;
          end
        end
      end
      E_MRD: if (mem_ready) begin
        hold_n = mem_lane;
        st_n   = E_PTX;
      end
      E_PRX: if (rx_valid) begin
        hold_n = rx_lane;
        st_n   = E_MWR;
      end
      default: ;
    endcase
    if (beat_done) begin
      adv = 1'b1;
      if (last_item) begin
        fin  = 1'b1;
        st_n = E_IDLE;
      end else if (burst_end) begin
        st_n = E_IDLE;
      end else begin
        bcnt_n = bcnt_q + 3'd1;
        st_n   = fetch_st;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= E_IDLE;
      bcnt_q <= '0;
      hold_q <= '0;
    end else begin
      st_q   <= st_n;
      bcnt_q <= bcnt_n;
      hold_q <= hold_n;
    end
  end

  assign mem_valid = (st_q == E_MRD) || (st_q == E_MWR);
  assign mem_we    = (st_q == E_MWR);
  assign mem_addr  = cur_addr;
  assign mem_be    = cfg.wide ? {BEW{1'b1}} : {{(BEW-1){1'b0}}, 1'b1};
  assign mem_wdata = hold_q;
  assign tx_valid  = (st_q == E_PTX);
  assign tx_data   = hold_q;
  assign rx_ready  = (st_q == E_PRX);
  assign dack      = (st_q != E_IDLE);
endmodule

// File: rtl/dbuf_dma_chan.sv
module dbuf_dma_chan
  import dbuf_dma_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 13,
  parameter int DW   = 16,
  parameter int NREQ = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [4:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW/8-1:0] mem_be,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic [NREQ-1:0] dreq,
  output logic            dack,
  output logic            tx_valid,
  input  logic            tx_ready,
  output logic [DW-1:0]   tx_data,
  input  logic            rx_valid,
  output logic            rx_ready,
  input  logic [DW-1:0]   rx_data,
  output logic            irq
);
  logic [7:0]    status_q, dev_q;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] cur_cnt, step;
  logic          adv, fin, err, strt_cur, wr_ok;
  logic [31:0]   rd_raw;

  assign wr_ok     = reg_we && (reg_addr[1:0] == 2'b00);
  assign reg_rdata = (reg_addr[1:0] == 2'b00) ? rd_raw : '0;
  assign strt_cur  = status_q[strt_pos(status_q[SB_BIU])];

  dbuf_dma_regs #(.AW(AW), .CW(CW), .RW(32)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_ok), .wr_idx(reg_addr[4:2]), .wr_data(reg_wdata),
    .rd_idx(reg_addr[4:2]), .rd_data(rd_raw),
    .eng_adv(adv), .eng_fin(fin), .eng_err(err), .eng_step(step),
    .status(status_q), .dev(dev_q), .cur_addr(cur_addr), .cur_cnt(cur_cnt));

  dbuf_dma_engine #(.AW(AW), .CW(CW), .DW(DW), .NREQ(NREQ)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .run(status_q[SB_RUN]), .strt_cur(strt_cur), .dev(dev_q),
    .cur_addr(cur_addr), .cur_cnt(cur_cnt), .dreq(dreq),
    .adv(adv), .fin(fin), .err(err), .step(step),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dack(dack),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data));

  assign irq = status_q[SB_IE] &
               (status_q[SB_ERR] | status_q[SB_DONEA] | status_q[SB_DONEB]);
endmodule

// File: rtl/dbuf_dma_chk.sv
module dbuf_dma_chk #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [4:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          irq,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [DW-1:0] tx_data,
  input logic          wide
);
  assert_irq_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 5'h08 && reg_wdata[1]) |=> !irq);

  assert_mem_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_we)));

  assert_tx_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_wide_even_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && wide) |-> !mem_addr[0]);
endmodule

bind dbuf_dma_chan dbuf_dma_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq(irq), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .wide(dev_q[3]));

// File: tb/sim_dbuf_dma_chan.sv
`timescale 1ns/1ps
module sim_dbuf_dma_chan;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [4:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        mem_valid, mem_we, dack, tx_valid, rx_ready, irq;
  logic        mem_ready = 1, tx_ready = 1, rx_valid = 1;
  logic [31:0] mem_addr;
  logic [1:0]  mem_be;
  logic [15:0] mem_wdata, tx_data;
  logic [15:0] mem_rdata = 0, rx_data = 0;
  logic [15:0] dreq = 16'hFFFF;

  int checks = 0, errors = 0;
  int act = 0, txn = 0, rx_idx = 0;
  logic [15:0] tcs = 0, wcs = 0;
  logic [7:0]  lfsr = 8'h5B;
  logic        stall = 0;

  always #2 clk = ~clk;

  dbuf_dma_chan u0 (.*);

  typedef struct packed {
    logic [7:0]  dev;
    logic [31:0] sa;
    logic [12:0] cnt;
    logic [7:0]  exp_stat;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{8'h20, 32'h1000, 13'd6,  8'h09},
    '{8'h3C, 32'h2000, 13'd20, 8'h09},
    '{8'h4A, 32'h3004, 13'd7,  8'h09},
    '{8'h51, 32'h4008, 13'd5,  8'h09},
    '{8'h6F, 32'h5010, 13'd12, 8'h09},
    '{8'h79, 32'h600C, 13'd18, 8'h09}
  };

  function automatic logic [15:0] roll(logic [15:0] c, logic [15:0] v);
    return {c[14:0], c[15]} ^ v;
  endfunction

  function automatic logic [15:0] lane(logic [15:0] d, logic [7:0] dev);
    if (!dev[3]) return {8'h00, d[7:0]};
    if (dev[1])  return {d[7:0], d[15:8]};
    return d;
  endfunction

  // expected checksum of one buffer, continuing from c
  function automatic logic [15:0] model(logic [15:0] c, logic [7:0] dev,
                                        logic [31:0] sa, int cnt, int rx0);
    int w = dev[3] ? 2 : 1;
    int beats = (cnt + w - 1) / w;
    logic [15:0] r = c;
    for (int k = 0; k < beats; k++) begin
      logic [31:0] a = sa + k * w;
      if (dev[0]) r = roll(r, lane(16'hA500 + 16'(rx0 + k), dev) ^ a[15:0]);
      else        r = roll(r, lane({a[7:0] + 8'd1, a[7:0]}, dev));
    end
    return r;
  endfunction

  // environment: stalls, memory data, peripheral data, monitors
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready = stall ? lfsr[0] : 1'b1;
      tx_ready  = stall ? lfsr[2] : 1'b1;
      rx_valid  = stall ? lfsr[4] : 1'b1;
      rx_data   = 16'hA500 + rx_idx[15:0];
      mem_rdata = {mem_addr[7:0] + 8'd1, mem_addr[7:0]};
      #1;
      if (rst_n) begin
        if (mem_valid && mem_ready) begin
          act++;
          if (mem_we) wcs = roll(wcs, mem_wdata ^ mem_addr[15:0]);
        end
        if (tx_valid && tx_ready) begin
          act++; txn++; tcs = roll(tcs, tx_data);
        end
        if (rx_valid && rx_ready) begin
          act++; rx_idx++;
        end
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #600000;
    checks++; errors++;
    $display("FAIL watchdog: all requirements, actual=hung expected=finished");
    summary();
    $finish;
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wait_stat(int bitn);
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(5'h0C, s);
      if (s[bitn]) break;
      @(negedge clk);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; stall = 0; dreq = 16'hFFFF;
    idle(3);
    rst_n = 1;
    act = 0; txn = 0; rx_idx = 0; tcs = 0; wcs = 0;
    idle(1);
  endtask

  initial begin
    logic [31:0] v;
    logic [15:0] e;
    int rem;

    do_reset();
    // R1: reset state
    rd(5'h0C, v); chk("R1 status after reset", v, 0);
    rd(5'h00, v); chk("R1 device byte after reset", v, 0);
    chk("R1 irq after reset", {31'b0, irq}, 0);

    // table-driven transfers under random stalls (R5 R6 R7 R13)
    foreach (VECS[i]) begin
      vec_t t = VECS[i];
      int w = t.dev[3] ? 2 : 1;
      stall = 1;
      wr(5'h08, 32'h7F);
      wr(5'h00, {24'b0, t.dev});
      wr(5'h10, t.sa);
      wr(5'h14, {19'b0, t.cnt});
      tcs = 0; wcs = 0; rx_idx = 0;
      wr(5'h04, 32'h11);
      wait_stat(3);
      idle(2);
      rd(5'h0C, v); chk("R7 status after buffer", v, {24'b0, t.exp_stat});
      rd(5'h10, v); chk("R5 final address", v, t.sa + ((t.cnt + w - 1) / w) * w);
      rd(5'h14, v); chk("R5 final count", v, 0);
      e = model(16'h0, t.dev, t.sa, t.cnt, 0);
      chk(t.dev[0] ? "R6 R13 memory write checksum" : "R6 R13 stream checksum",
          {16'b0, t.dev[0] ? wcs : tcs}, {16'b0, e});
    end
    stall = 0;

    // R2 R3 R4: aliases and configuration
    do_reset();
    wr(5'h04, 32'h82);
    rd(5'h0C, v); chk("R2 set alias, bit 7 ignored", v, 32'h02);
    wr(5'h04, 32'h00);
    wr(5'h08, 32'h00);
    rd(5'h0C, v); chk("R2 zero writes leave status", v, 32'h02);
    rd(5'h04, v); chk("R2 set alias reads zero", v, 0);
    wr(5'h08, 32'h02);
    rd(5'h0C, v); chk("R3 interrupt enable at bit 1 cleared", v, 0);
    wr(5'h00, 32'hA5);
    rd(5'h00, v); chk("R4 device byte readback", v, 32'hA5);

    // R9: zero count
    do_reset();
    wr(5'h10, 32'h40);
    wr(5'h04, 32'h13);
    idle(4);
    rd(5'h0C, v); chk("R9 zero count done", v, 32'h0B);
    chk("R9 no bus activity", act, 0);
    chk("R8 irq on done with enable", {31'b0, irq}, 1);
    wr(5'h08, 32'h08);
    chk("R8 irq dropped after clear", {31'b0, irq}, 0);

    // R10: misaligned start
    do_reset();
    wr(5'h00, 32'h20);
    wr(5'h10, 32'h102);
    wr(5'h14, 32'd8);
    wr(5'h04, 32'h13);
    idle(4);
    rd(5'h0C, v); chk("R10 error set run cleared", v, 32'h16);
    chk("R10 no bus activity", act, 0);
    chk("R8 irq on error", {31'b0, irq}, 1);
    wr(5'h08, 32'h04);
    chk("R8 irq dropped after error clear", {31'b0, irq}, 0);

    // R12: request line gating
    do_reset();
    dreq = 16'hFFDF;
    wr(5'h00, 32'h50);
    wr(5'h10, 32'h500);
    wr(5'h14, 32'd4);
    wr(5'h04, 32'h11);
    idle(20);
    chk("R12 idle while selected request low", act, 0);
    dreq = 16'hFFFF;
    wait_stat(3);
    idle(1);
    rd(5'h0C, v); chk("R12 done once request high", v, 32'h09);

    // R11: pause at burst boundary and resume, 8-item bursts
    do_reset();
    wr(5'h00, 32'h14);
    wr(5'h10, 32'h300);
    wr(5'h14, 32'd40);
    wr(5'h04, 32'h11);
    idle(9);
    wr(5'h08, 32'h01);
    idle(30);
    rem = act;
    idle(20);
    chk("R11 no activity while paused", act, rem);
    rd(5'h14, v); rem = int'(v);
    chk("R11 stop on burst boundary", ((40 - rem) % 8 == 0 && rem > 0 && rem < 40) ? 1 : 0, 1);
    rd(5'h10, v); chk("R11 address kept", v, 32'h300 + 32'(40 - rem));
    wr(5'h04, 32'h01);
    wait_stat(3);
    idle(1);
    chk("R11 R12 item count after resume", txn, 40);
    chk("R11 checksum after resume", {16'b0, tcs}, {16'b0, model(16'h0, 8'h14, 32'h300, 40, 0)});

    // R7: ping-pong hand-over A then B
    do_reset();
    wr(5'h00, 32'h20);
    wr(5'h10, 32'h100);
    wr(5'h14, 32'd4);
    wr(5'h18, 32'h200);
    wr(5'h1C, 32'd6);
    wr(5'h04, 32'h51);
    wait_stat(5);
    idle(2);
    rd(5'h0C, v); chk("R7 both done, B in use", v, 32'hA9);
    rd(5'h18, v); chk("R7 B final address", v, 32'h206);
    e = model(model(16'h0, 8'h20, 32'h100, 4, 0), 8'h20, 32'h200, 6, 0);
    chk("R7 checksum over A then B", {16'b0, tcs}, {16'b0, e});

    summary();
    $finish;
  end
endmodule